// File: doc/BRIEF.md
# Adaptive Segmented OLS Line Codec

This block encodes and decodes a fixed 352-bit memory line with Orthogonal Latin Square (OLS) codes. A mode input set by system software selects one of two layouts. In regular mode the line holds 256 data bits and a single OLS code that corrects up to three errors. In enhanced mode the same 352 bits hold only 192 data bits. That data is split into two 64-bit segments, each with its own three-error OLS code, and four 16-bit segments, each with its own two-error OLS code. Each segment is encoded and decoded on its own.

The write path turns a data word into a line. The read path turns a stored line into corrected data in one combinational majority-vote step. Both results are registered, so they appear one clock after the inputs. For every data bit of an m×m segment, the decoder counts how many of its 2t parity groups fail and inverts the bit when more than t of them fail. Check bits are never rewritten. The read side also reports how many data bits are valid for the current mode.

Top module: `ols_line_codec`

## Requirements
- R1: The reset input is synchronous and active high. After a rising edge with reset high, `wr_line` and `rd_data` read zero and `data_width` reads 256, whatever the other inputs are. When reset is low, every output shows the result for the inputs of the previous edge, one cycle of latency.
- R2: Regular write layout and code construction.
  - The line carries data in [255:0] and 96 check bits in [351:256].
  - Within an m×m segment (m=2^n), data bit d = i·m+j sits in group g with symbol s: g=0 uses s=i, g=1 uses s=j, and g≥2 uses s = i XOR ((g−1)·j).
  - The product is taken in GF(2^n) with polynomial x^4+x+1, x^3+x+1 or x^2+x+1 for n = 4, 3 or 2.
  - The check bit at segment offset g·m+s is the XOR of its group.
  - In regular mode n=4 and g ranges over 0..5.
- R3: Enhanced write layout.
  - Data segments sit in this order: segment A = data[63:0] at line[63:0], segment B = data[127:64] at line[127:64], and 16-bit segments k=0..3 = data[128+16k +: 16] at the same positions.
  - Check bits follow: A at [239:192], B at [287:240], and 16-bit segment k at [288+16k +: 16].
  - The 64-bit segments use n=3 with g in 0..5. The 16-bit segments use n=2 with g in 0..3.
- R4: In enhanced mode, `wr_data[255:192]` has no effect on `wr_line`.
- R5: In regular mode, any pattern of up to 3 flipped bits anywhere in the 352-bit line is corrected, and `rd_data` equals the written data.
- R6: In enhanced mode, the decoder corrects up to 3 flipped bits in each 64-bit segment (counting its data and check bits) and up to 2 in each 16-bit segment, all at the same time. Errors in one segment never disturb another segment.
- R7: `data_width` is 192 after an enhanced read cycle, with `rd_data[255:192]` zero and the data right-aligned. It is 256 after a regular cycle.
- R8: Mode is taken per cycle. Consecutive cycles may alternate modes, and each result follows the mode of its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_enh | input | 1 | 0 = regular layout, 1 = enhanced segmented layout |
| wr_data | input | 256 | Data to encode (only [191:0] used when enhanced) |
| wr_line | output | 352 | Registered encoded line |
| rd_line | input | 352 | Stored line to decode |
| rd_data | output | 256 | Registered corrected data, right-aligned |
| data_width | output | 9 | Number of valid data bits (256 or 192) |

## Verification
The bench computes the check bits independently and compares every encoded line bit for bit. A mistake in a Latin-square multiplier or a check-bit offset therefore shows up as a wrong line, even where the write and read sides would agree with each other. It flips the maximum correctable number of bits in every segment at once, with positions spread over data and check bits. This catches a vote threshold that is off by one, as well as segment boundaries that leak errors across segments. Other directed cases cover errors placed only in check bits, a change in the upper data bits in enhanced mode, which must not alter the line, and the mode toggling on back-to-back cycles. A design that latched the mode late would fail that last case.

// File: rtl/ols_pkg.sv
package ols_pkg;

  // GF(2^n) product, n in 2..4
  function automatic int gf_mul(input int a, input int b, input int n);
    int p;
    int r;
    int poly;
    poly = (n == 2) ? 7 : ((n == 3) ? 11 : 19);
    r = 0;
    p = a;
    for (int k = 0; k < n; k++) begin
      if (((b >> k) & 1) != 0) r = r ^ p;
      p = p << 1;
      if (((p >> n) & 1) != 0) p = p ^ poly;
    end
    return r;
  endfunction

  // symbol of data bit (i,j) inside parity group g
  function automatic int grp_sym(input int g, input int i, input int j, input int n);
    if (g == 0) return i;
    if (g == 1) return j;
    return i ^ gf_mul(g - 1, j, n);
  endfunction

endpackage

// File: rtl/ols_enc.sv
module ols_enc #(
  parameter int N = 4,
  parameter int T = 3,
  localparam int M = 1 << N,
  localparam int D = M * M,
  localparam int C = 2 * T * M
) (
  input  logic [D-1:0] data,
  output logic [C-1:0] chk
);

  always_comb begin
    chk = '0;
    for (int i = 0; i < M; i++) begin
      for (int j = 0; j < M; j++) begin
        for (int g = 0; g < 2 * T; g++) begin
          chk[g*M + ols_pkg::grp_sym(g, i, j, N)] ^= data[i*M + j];
        end
      end
    end
  end

endmodule

// File: rtl/ols_dec.sv
module ols_dec #(
  parameter int N = 4,
  parameter int T = 3,
  localparam int M = 1 << N,
  localparam int D = M * M,
  localparam int C = 2 * T * M
) (
  input  logic [D-1:0] data,
  input  logic [C-1:0] chk,
  output logic [D-1:0] fixed
);

  logic [C-1:0] rechk;
  logic [C-1:0] syn;

  ols_enc #(.N(N), .T(T)) u_enc (
    .data (data),
    .chk  (rechk)
  );

  assign syn = rechk ^ chk;

  // one-step majority vote per data bit
  always_comb begin
    for (int i = 0; i < M; i++) begin
      for (int j = 0; j < M; j++) begin
        int votes;
        votes = 0;
        for (int g = 0; g < 2 * T; g++) begin
          votes += int'(syn[g*M + ols_pkg::grp_sym(g, i, j, N)]);
        end
        fixed[i*M + j] = data[i*M + j] ^ (votes > T);
      end
    end
  end

  always_comb begin
    if (syn == '0) begin
      AST_CLEAN_PASS: assert (fixed == data); // R5 R6
    end
  end

endmodule

// File: rtl/ols_line_codec.sv
module ols_line_codec #(
  parameter int REG_N     = 4,
  parameter int REG_T     = 3,
  parameter int BIG_N     = 3,
  parameter int BIG_T     = 3,
  parameter int BIG_CNT   = 2,
  parameter int SMALL_N   = 2,
  parameter int SMALL_T   = 2,
  parameter int SMALL_CNT = 4,
  localparam int REG_D    = (1 << REG_N) * (1 << REG_N),
  localparam int REG_C    = 2 * REG_T * (1 << REG_N),
  localparam int LINE_W   = REG_D + REG_C,
  localparam int WID_W    = $clog2(REG_D + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_enh,
  input  logic [REG_D-1:0]  wr_data,
  output logic [LINE_W-1:0] wr_line,
  input  logic [LINE_W-1:0] rd_line,
  output logic [REG_D-1:0]  rd_data,
  output logic [WID_W-1:0]  data_width
);

  localparam int BIG_D   = (1 << BIG_N) * (1 << BIG_N);
  localparam int BIG_C   = 2 * BIG_T * (1 << BIG_N);
  localparam int SMALL_D = (1 << SMALL_N) * (1 << SMALL_N);
  localparam int SMALL_C = 2 * SMALL_T * (1 << SMALL_N);
  localparam int ENH_D   = BIG_CNT * BIG_D + SMALL_CNT * SMALL_D;
  localparam int SM_DOFF = BIG_CNT * BIG_D;
  localparam int SM_COFF = ENH_D + BIG_CNT * BIG_C;

  logic [REG_C-1:0]   reg_chk;
  logic [REG_D-1:0]   reg_fix;
  logic [BIG_C-1:0]   big_chk   [BIG_CNT];
  logic [BIG_D-1:0]   big_fix   [BIG_CNT];
  logic [SMALL_C-1:0] small_chk [SMALL_CNT];
  logic [SMALL_D-1:0] small_fix [SMALL_CNT];
  logic [LINE_W-1:0]  enh_line;
  logic [REG_D-1:0]   enh_data;

  // regular single-code path
  ols_enc #(.N(REG_N), .T(REG_T)) u_reg_enc (
    .data (wr_data),
    .chk  (reg_chk)
  );

  ols_dec #(.N(REG_N), .T(REG_T)) u_reg_dec (
    .data  (rd_line[REG_D-1:0]),
    .chk   (rd_line[LINE_W-1:REG_D]),
    .fixed (reg_fix)
  );

  // enhanced path: wide segments
  for (genvar b = 0; b < BIG_CNT; b++) begin : g_big
    ols_enc #(.N(BIG_N), .T(BIG_T)) u_enc (
      .data (wr_data[b*BIG_D +: BIG_D]),
      .chk  (big_chk[b])
    );
    ols_dec #(.N(BIG_N), .T(BIG_T)) u_dec (
      .data  (rd_line[b*BIG_D +: BIG_D]),
      .chk   (rd_line[ENH_D + b*BIG_C +: BIG_C]),
      .fixed (big_fix[b])
    );
  end

  // enhanced path: narrow segments
  for (genvar s = 0; s < SMALL_CNT; s++) begin : g_small
    ols_enc #(.N(SMALL_N), .T(SMALL_T)) u_enc (
      .data (wr_data[SM_DOFF + s*SMALL_D +: SMALL_D]),
      .chk  (small_chk[s])
    );
    ols_dec #(.N(SMALL_N), .T(SMALL_T)) u_dec (
      .data  (rd_line[SM_DOFF + s*SMALL_D +: SMALL_D]),
      .chk   (rd_line[SM_COFF + s*SMALL_C +: SMALL_C]),
      .fixed (small_fix[s])
    );
  end

  always_comb begin
    enh_line = '0;
    enh_data = '0;
    enh_line[ENH_D-1:0] = wr_data[ENH_D-1:0];
    for (int b = 0; b < BIG_CNT; b++) begin
      enh_line[ENH_D + b*BIG_C +: BIG_C] = big_chk[b];
      enh_data[b*BIG_D +: BIG_D]         = big_fix[b];
    end
    for (int s = 0; s < SMALL_CNT; s++) begin
      enh_line[SM_COFF + s*SMALL_C +: SMALL_C] = small_chk[s];
      enh_data[SM_DOFF + s*SMALL_D +: SMALL_D] = small_fix[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_line    <= '0;
      rd_data    <= '0;
      data_width <= WID_W'(REG_D);
    end else begin
      wr_line    <= mode_enh ? enh_line : {reg_chk, wr_data};
      rd_data    <= mode_enh ? enh_data : reg_fix;
      data_width <= mode_enh ? WID_W'(ENH_D) : WID_W'(REG_D);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_line == '0 && rd_data == '0 && data_width == WID_W'(REG_D))); // R1

  AST_WIDTH_TRACKS_MODE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (data_width == ($past(mode_enh) ? WID_W'(ENH_D) : WID_W'(REG_D)))); // R7

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(mode_enh) |-> (rd_data[REG_D-1:ENH_D] == '0)); // R7

  AST_REG_SYSTEMATIC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_enh)) |-> (wr_line[REG_D-1:0] == $past(wr_data))); // R2

  AST_ENH_SYSTEMATIC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_enh)) |-> (wr_line[ENH_D-1:0] == $past(wr_data[ENH_D-1:0]))); // R3

endmodule

// File: tb/ols_line_codec_bench.sv
`timescale 1ns/1ps
module ols_line_codec_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_enh = 1'b0;
  logic [255:0] wr_data = '0;
  logic [351:0] wr_line;
  logic [351:0] rd_line = '0;
  logic [255:0] rd_data;
  logic [8:0]   data_width;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ols_line_codec u_ols_line_codec (
    .clk        (clk),
    .rst        (rst),
    .mode_enh   (mode_enh),
    .wr_data    (wr_data),
    .wr_line    (wr_line),
    .rd_line    (rd_line),
    .rd_data    (rd_data),
    .data_width (data_width)
  );

  // bit 3 = enhanced mode, bits 2:0 = errors injected per segment
  localparam logic [3:0] VEC [12] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9,
                                      4'hA, 4'hB, 4'h3, 4'hB, 4'h2, 4'hA};
  localparam int TRIALS = 16;

  task automatic check(input string tag, input logic [351:0] act, input logic [351:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // field product by repeated doubling
  function automatic int tb_mul(input int a, input int b, input int n);
    int acc;
    int x;
    int red;
    red = (n == 4) ? 'h13 : ((n == 3) ? 'hB : 'h7);
    acc = 0;
    x = b;
    for (int k = 0; k < n; k++) begin
      if (a[k]) acc ^= x;
      x = x << 1;
      if (x >= (1 << n)) x ^= red;
    end
    return acc;
  endfunction

  function automatic void add_seg(inout logic [351:0] ln, input int db, input int cb,
                                  input int n, input int t);
    int m;
    int s;
    m = 1 << n;
    for (int i = 0; i < m; i++)
      for (int j = 0; j < m; j++)
        if (ln[db + i*m + j])
          for (int g = 0; g < 2*t; g++) begin
            s = (g == 0) ? i : ((g == 1) ? j : (i ^ tb_mul(g - 1, j, n)));
            ln[cb + g*m + s] ^= 1'b1;
          end
  endfunction

  function automatic logic [351:0] ref_line(input logic m, input logic [255:0] d);
    logic [351:0] ln;
    ln = '0;
    if (!m) begin
      ln[255:0] = d;
      add_seg(ln, 0, 256, 4, 3);
    end else begin
      ln[191:0] = d[191:0];
      add_seg(ln, 0, 192, 3, 3);
      add_seg(ln, 64, 240, 3, 3);
      for (int k = 0; k < 4; k++) add_seg(ln, 128 + 16*k, 288 + 16*k, 2, 2);
    end
    return ln;
  endfunction

  function automatic void flip(inout logic [351:0] ln, input int db, input int dl,
                               input int cb, input int cl, input int ne);
    logic [351:0] used;
    int p;
    int idx;
    used = '0;
    for (int e = 0; e < ne; e++) begin
      do begin
        p = $urandom_range(dl + cl - 1, 0);
        idx = (p < dl) ? db + p : cb + p - dl;
      end while (used[idx]);
      used[idx] = 1'b1;
      ln[idx] ^= 1'b1;
    end
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom();
    return v;
  endfunction

  task automatic trial(input logic m, input int ne);
    logic [255:0] d;
    logic [351:0] ln;
    int ns;
    d = rnd256();
    mode_enh = m;
    wr_data = d;
    @(negedge clk);
    check(m ? "R3 enc" : "R2 enc", wr_line, ref_line(m, d));
    ln = ref_line(m, d);
    if (!m) flip(ln, 0, 256, 256, 96, ne);
    else begin
      ns = (ne > 2) ? 2 : ne;
      flip(ln, 0, 64, 192, 48, ne);
      flip(ln, 64, 64, 240, 48, ne);
      for (int k = 0; k < 4; k++) flip(ln, 128 + 16*k, 16, 288 + 16*k, 16, ns);
    end
    rd_line = ln;
    @(negedge clk);
    check(m ? "R6 dec" : "R5 dec", {96'd0, rd_data}, m ? {160'd0, d[191:0]} : {96'd0, d});
    check("R7 width", {343'd0, data_width}, m ? 352'd192 : 352'd256);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] d;
    logic [351:0] ln;
    // R1: reset with busy inputs
    rst = 1'b1;
    mode_enh = 1'b1;
    wr_data = '1;
    rd_line = '1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset line", wr_line, '0);
    check("R1 reset data", {96'd0, rd_data}, '0);
    check("R1 reset width", {343'd0, data_width}, 352'd256);
    rst = 1'b0;

    // table walk
    for (int v = 0; v < 12; v++)
      for (int r = 0; r < TRIALS; r++)
        trial(VEC[v][3], int'(VEC[v][2:0]));

    // R4: upper bits ignored in enhanced mode
    d = rnd256();
    mode_enh = 1'b1;
    wr_data = {64'h0, d[191:0]};
    @(negedge clk);
    check("R4 upper zero", wr_line, ref_line(1'b1, d));
    wr_data = {~d[255:192] | 64'h1, d[191:0]};
    @(negedge clk);
    check("R4 upper set", wr_line, ref_line(1'b1, d));

    // R5: three errors confined to check bits
    d = rnd256();
    ln = ref_line(1'b0, d);
    ln[256] ^= 1'b1;
    ln[300] ^= 1'b1;
    ln[351] ^= 1'b1;
    mode_enh = 1'b0;
    rd_line = ln;
    @(negedge clk);
    check("R5 check-only errors", {96'd0, rd_data}, {96'd0, d});

    // R6: three errors in one wide segment, others clean
    ln = ref_line(1'b1, d);
    ln[0] ^= 1'b1;
    ln[9] ^= 1'b1;
    ln[63] ^= 1'b1;
    mode_enh = 1'b1;
    rd_line = ln;
    @(negedge clk);
    check("R6 segment isolation", {96'd0, rd_data}, {160'd0, d[191:0]});

    // R8: mode alternates on back-to-back cycles
    d = rnd256();
    wr_data = d;
    mode_enh = 1'b0;
    @(negedge clk);
    check("R8 regular cycle", wr_line, ref_line(1'b0, d));
    mode_enh = 1'b1;
    @(negedge clk);
    check("R8 enhanced cycle", wr_line, ref_line(1'b1, d));
    check("R8 width follows", {343'd0, data_width}, 352'd192);
    mode_enh = 1'b0;
    @(negedge clk);
    check("R8 back to regular", wr_line, ref_line(1'b0, d));

    // R1: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    check("R1 midrun line", wr_line, '0);
    check("R1 midrun data", {96'd0, rd_data}, '0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule